// File: doc/BRIEF.md
# ASCII Hex Command Word Assembler

This block sits behind a serial receiver and turns a stream of received bytes into one wide command word. Each byte is presented on an 8-bit bus with a one-cycle strobe. Hex digit characters are turned into 4-bit values and shifted into a 52-bit register. A carriage return hands the finished word to the downstream execution logic. A space throws away whatever has been typed so far.

Each digit enters at the low end of the register and pushes the earlier digits up. A full command of thirteen digits therefore ends with its first digit in the top nibble. A short command has zeros above the digits it supplied. A long command keeps only its last thirteen digits. Any other byte is dropped and raises a sticky error flag. The next commit or clear lowers the flag. The committed word stays on its output until the next commit. A one-cycle pulse marks each new word.

Top module: `ascii_cmd_assembler`

## Requirements
- R1: While reset is low and in the first cycle after it, `cmd_valid` is 0, `char_err` is 0 and `cmd_word` is all zeros.
- R2: A byte accepted with `rx_valid` high is a hex digit when it is 0x30..0x39 (value 0..9), 0x41..0x46 or 0x61..0x66 (value 10..15 in both letter cases).
- R3: Each accepted digit shifts the assembled word left by 4 bits and enters in bits [3:0], so with 13 digits the first digit sits in bits [51:48].
- R4: When fewer than 13 digits precede the commit, every bit above the supplied digits in `cmd_word` is zero.
- R5: When more than 13 digits precede the commit, only the last 13 digits remain and the older ones are lost off the top.
- R6: An accepted 0x0D byte raises `cmd_valid` for exactly the next cycle, with `cmd_word` carrying the assembled word. `cmd_word` keeps that value until the next commit.
- R7: After a commit the assembly register starts empty, so the next command holds only digits received after that commit.
- R8: An accepted 0x20 byte discards the partial word without raising `cmd_valid`.
- R9: Any other accepted byte leaves the partial word unchanged and sets `char_err` in the next cycle.
- R10: `char_err` stays set across later digits and is cleared in the cycle after an accepted 0x0D or 0x20, including when a commit follows an error.
- R11: A byte presented with `rx_valid` low has no effect on the assembled word, `cmd_valid` or `char_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_data` |
| cmd_word | output | 52 | Last committed command word |
| cmd_valid | output | 1 | One-cycle pulse when a new word is committed |
| char_err | output | 1 | Sticky flag for rejected bytes |

## Verification
A commit that follows a rejected byte makes two things happen at one edge. The new word is released with its pulse, and the error flag drops. The bench provokes this by sending a bad character in the middle of a digit string and then a carriage return. It then checks that the pulse, the expected word and the low error flag all appear in the same sampled cycle. The bench also sends back-to-back carriage returns, so that the clearing from one commit meets the release of the next. There it expects two pulses in a row, with the second word all zero.

// File: rtl/ascii_cmd_pkg.sv
// Package: ascii_cmd_pkg
// Shared types for the ASCII hex command assembler. It assumes
// digits are 4 bits wide, which fixes the nibble width.
package ascii_cmd_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        CH_DIGIT  = 2'd0,
        CH_COMMIT = 2'd1,
        CH_CLEAR  = 2'd2,
        CH_BAD    = 2'd3
    } char_kind_t;

    typedef struct packed {
        char_kind_t       kind;
        logic [NIB_W-1:0] value;
    } char_info_t;

endpackage

// File: rtl/hex_char_decoder.sv
// Module: hex_char_decoder
// Sorts one byte into digit, commit, clear or bad, and gives the
// 4-bit digit value. It is purely combinational. It assumes the
// control byte codes differ from every hex digit code.
module hex_char_decoder
    import ascii_cmd_pkg::*;
#(
    parameter logic [7:0] COMMIT_CODE = 8'h0D,
    parameter logic [7:0] CLEAR_CODE  = 8'h20
) (
    input  logic [7:0] byte_in,
    output char_info_t info
);

    logic [7:0] offset;

    // Classify the byte and derive the digit value from its code.
    always_comb begin
        offset     = 8'h00;
        info.kind  = CH_BAD;
        if (byte_in >= 8'h30 && byte_in <= 8'h39) begin
            offset    = byte_in - 8'h30;
            info.kind = CH_DIGIT;
        end else if (byte_in >= 8'h41 && byte_in <= 8'h46) begin
            offset    = byte_in - 8'h37;
            info.kind = CH_DIGIT;
        end else if (byte_in >= 8'h61 && byte_in <= 8'h66) begin
            offset    = byte_in - 8'h57;
            info.kind = CH_DIGIT;
        end else if (byte_in == COMMIT_CODE) begin
            info.kind = CH_COMMIT;
        end else if (byte_in == CLEAR_CODE) begin
            info.kind = CH_CLEAR;
        end
        info.value = offset[NIB_W-1:0];
    end

endmodule

// File: rtl/cmd_shift_reg.sv
// Module: cmd_shift_reg
// Nibble-wide shift register. Each shift puts a new nibble in the
// lowest slot and moves every slot up one place. A clear empties
// all slots and wins over a shift; the two do not occur together.
module cmd_shift_reg
    import ascii_cmd_pkg::*;
#(
    parameter int DIGITS = 13,
    localparam int WORD_W = DIGITS * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              clear,
    input  logic [NIB_W-1:0]  nibble_in,
    output logic [WORD_W-1:0] word
);

    for (genvar g = 0; g < DIGITS; g++) begin : g_slot
        logic [NIB_W-1:0] src;

        if (g == 0) begin : g_head
            // The lowest slot takes the incoming nibble.
            assign src = nibble_in;
        end else begin : g_body
            // Every higher slot takes its lower neighbour.
            assign src = word[(g-1)*NIB_W +: NIB_W];
        end

        // Hold, clear or shift this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word[g*NIB_W +: NIB_W] <= '0;
            end else if (shift_en) begin
                word[g*NIB_W +: NIB_W] <= src;
            end
        end
    end

endmodule

// File: rtl/err_tracker.sv
// Module: err_tracker
// Sticky error flag. A set raises it and a clear lowers it. A clear
// wins, although the decoder never asks for both at once.
module err_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/cmd_release.sv
// Module: cmd_release
// Captures the assembled word on a commit and pulses a valid for one
// cycle. It assumes the shift register is cleared at the same edge,
// so it captures the value from before that clear.
module cmd_release #(
    parameter int WORD_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              valid_out
);

    // Hold the last committed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
        end else if (commit) begin
            word_out <= word_in;
        end
    end

    // One pulse per commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= commit;
        end
    end

endmodule

// File: rtl/ascii_cmd_assembler.sv
// Module: ascii_cmd_assembler (top)
// Builds a command word from hex digit characters given one byte at a
// time with a valid strobe. A carriage return commits the word and a
// space clears it. Any other byte is ignored and flagged. All outputs
// are registered, so each byte takes effect one cycle after it is taken.
module ascii_cmd_assembler
    import ascii_cmd_pkg::*;
#(
    parameter int         DIGITS      = 13,
    parameter logic [7:0] COMMIT_CODE = 8'h0D,
    parameter logic [7:0] CLEAR_CODE  = 8'h20,
    localparam int        WORD_W      = DIGITS * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_valid,
    output logic              char_err
);

    char_info_t        info;
    logic              do_shift;
    logic              do_commit;
    logic              do_clear;
    logic              do_flag;
    logic [WORD_W-1:0] asm_word;

    hex_char_decoder #(
        .COMMIT_CODE (COMMIT_CODE),
        .CLEAR_CODE  (CLEAR_CODE)
    ) u_dec (
        .byte_in (rx_data),
        .info    (info)
    );

    // Turn the byte class into one-hot actions, qualified by the strobe.
    always_comb begin
        do_shift  = rx_valid && (info.kind == CH_DIGIT);
        do_commit = rx_valid && (info.kind == CH_COMMIT);
        do_clear  = rx_valid && (info.kind == CH_COMMIT || info.kind == CH_CLEAR);
        do_flag   = rx_valid && (info.kind == CH_BAD);
    end

    cmd_shift_reg #(
        .DIGITS (DIGITS)
    ) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (do_shift),
        .clear     (do_clear),
        .nibble_in (info.value),
        .word      (asm_word)
    );

    err_tracker u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (do_flag),
        .clr   (do_clear),
        .flag  (char_err)
    );

    cmd_release #(
        .WORD_W (WORD_W)
    ) u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (do_commit),
        .word_in   (asm_word),
        .word_out  (cmd_word),
        .valid_out (cmd_valid)
    );

endmodule

// File: rtl/ascii_cmd_checker.sv
// Module: ascii_cmd_checker
// Port-level properties of the assembler, bound to the top module.
// It decodes the byte classes on its own from the requirements.
module ascii_cmd_checker #(
    parameter int         WORD_W      = 52,
    parameter logic [7:0] COMMIT_CODE = 8'h0D,
    parameter logic [7:0] CLEAR_CODE  = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rx_data,
    input logic              rx_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic              cmd_valid,
    input logic              char_err
);

    logic is_hex;
    logic is_cr;
    logic is_sp;
    logic is_bad;

    // Classify the presented byte the way the requirements describe it.
    always_comb begin
        is_hex = (rx_data >= 8'h30 && rx_data <= 8'h39) ||
                 (rx_data >= 8'h41 && rx_data <= 8'h46) ||
                 (rx_data >= 8'h61 && rx_data <= 8'h66);
        is_cr  = (rx_data == COMMIT_CODE);
        is_sp  = (rx_data == CLEAR_CODE);
        is_bad = !is_hex && !is_cr && !is_sp;
    end

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && is_cr) |=> cmd_valid);  // R6
    AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && is_cr) |=> !cmd_valid);  // R6
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_word));  // R6
    AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && is_bad) |=> char_err);  // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (is_cr || is_sp)) |=> !char_err);  // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && is_hex) |=> $stable(char_err));  // R10
    AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(char_err));  // R11

endmodule

bind ascii_cmd_assembler ascii_cmd_checker #(
    .WORD_W      (WORD_W),
    .COMMIT_CODE (COMMIT_CODE),
    .CLEAR_CODE  (CLEAR_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .cmd_word  (cmd_word),
    .cmd_valid (cmd_valid),
    .char_err  (char_err)
);

// File: tb/test_ascii_cmd_assembler.sv
module test_ascii_cmd_assembler;

    localparam int CLK_PERIOD = 10;
    localparam int DIGITS     = 13;
    localparam int WORD_W     = DIGITS * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_valid = 1'b0;
    logic [WORD_W-1:0] cmd_word;
    logic              cmd_valid;
    logic              char_err;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ascii_cmd_assembler #(.DIGITS(DIGITS)) i_ascii_cmd_assembler (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .cmd_word  (cmd_word),
        .cmd_valid (cmd_valid),
        .char_err  (char_err)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one byte for one cycle; return at the following negedge,
    // when the registered outputs show its effect.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send(s[i]);
    endtask

    function automatic bit is_digit(input logic [7:0] b);
        return (b >= 8'h30 && b <= 8'h39) || (b >= 8'h41 && b <= 8'h46) ||
               (b >= 8'h61 && b <= 8'h66);
    endfunction

    function automatic logic [3:0] digit_val(input logic [7:0] b);
        logic [7:0] v;
        if (b <= 8'h39)      v = b - 8'd48;
        else if (b <= 8'h46) v = b - 8'd55;
        else                 v = b - 8'd87;
        return v[3:0];
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] held;
        repeat (3) @(negedge clk);
        chk(cmd_valid == 0 && char_err == 0 && cmd_word == 0, "R1 in reset",
            {cmd_word[7:0], cmd_valid, char_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 0 && char_err == 0 && cmd_word == 0, "R1 after reset",
            {cmd_word[7:0], cmd_valid, char_err}, 0);

        // Sweep of every byte value: classification and single-digit value.
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bv;
            bit bad;
            bv  = b[7:0];
            bad = !is_digit(bv) && bv != 8'h0D && bv != 8'h20;
            send(8'h20);
            send(bv);
            chk(char_err == bad, $sformatf("R9 flag for byte %02h", bv), char_err, bad);
            chk(cmd_valid == (bv == 8'h0D), $sformatf("R6 pulse for byte %02h", bv),
                cmd_valid, bv == 8'h0D);
            send(8'h0D);
            chk(cmd_valid == 1, "R6 commit pulse", cmd_valid, 1);
            chk(cmd_word == (is_digit(bv) ? {48'h0, digit_val(bv)} : '0),
                $sformatf("R2 value for byte %02h", bv), cmd_word,
                is_digit(bv) ? {48'h0, digit_val(bv)} : '0);
            chk(char_err == 0, "R10 commit clears flag", char_err, 0);
        end

        // Full 13-digit command: first digit lands in the top nibble.
        send_str("123456789ABCD");
        send(8'h0D);
        chk(cmd_word == 52'h123456789ABCD, "R3 full word", cmd_word, 52'h123456789ABCD);
        held = cmd_word;
        @(negedge clk);
        chk(cmd_valid == 0, "R6 pulse lasts one cycle", cmd_valid, 0);
        chk(cmd_word == held, "R6 word held", cmd_word, held);

        // Over-long command drops the oldest digits.
        send_str("FEDCBA987654321");
        send(8'h0D);
        chk(cmd_word == 52'hDCBA987654321, "R5 overflow", cmd_word, 52'hDCBA987654321);

        // Short command is zero-extended; lower-case letters.
        send_str("a5");
        send(8'h0D);
        chk(cmd_word == 52'hA5, "R4 short word", cmd_word, 52'hA5);

        // Register starts empty after a commit.
        send_str("7");
        send(8'h0D);
        chk(cmd_word == 52'h7, "R7 fresh after commit", cmd_word, 52'h7);

        // Space discards the partial word and gives no pulse.
        send_str("ABC");
        send(8'h20);
        chk(cmd_valid == 0, "R8 no pulse on clear", cmd_valid, 0);
        send_str("12");
        send(8'h0D);
        chk(cmd_word == 52'h12, "R8 partial discarded", cmd_word, 52'h12);

        // Bad byte mid-command: sticky flag, word untouched, clear on commit.
        send_str("1");
        send(8'h47);
        chk(char_err == 1, "R9 flag set", char_err, 1);
        send_str("2");
        chk(char_err == 1, "R10 flag sticky over digit", char_err, 1);
        send(8'h0D);
        chk(cmd_valid == 1 && char_err == 0, "R10 commit and flag clear same cycle",
            {cmd_valid, char_err}, 2'b10);
        chk(cmd_word == 52'h12, "R9 bad byte ignored", cmd_word, 52'h12);

        // Space clears the flag.
        send(8'h7E);
        send(8'h20);
        chk(char_err == 0, "R10 space clears flag", char_err, 0);

        // Bytes without the strobe are ignored.
        send_str("9");
        @(negedge clk);
        rx_data = 8'h0D;
        repeat (3) begin
            @(negedge clk);
            chk(cmd_valid == 0, "R11 no pulse without strobe", cmd_valid, 0);
        end
        rx_data = 8'h58;
        repeat (2) @(negedge clk);
        chk(char_err == 0, "R11 no flag without strobe", char_err, 0);
        rx_data = 8'h35;
        repeat (2) @(negedge clk);
        send(8'h0D);
        chk(cmd_word == 52'h9, "R11 word unchanged without strobe", cmd_word, 52'h9);

        // Back-to-back commits: second word is empty.
        send_str("44");
        @(negedge clk);
        rx_data  = 8'h0D;
        rx_valid = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 1 && cmd_word == 52'h44, "R6 first of two commits",
            cmd_word, 52'h44);
        @(negedge clk);
        rx_valid = 1'b0;
        chk(cmd_valid == 1 && cmd_word == 0, "R7 second commit empty", cmd_word, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule